// File: doc/BRIEF.md
# Antenna Diversity Acquisition Controller

This block decides which of two antennas is connected during clear-channel assessment, transmit and receive acquisition. It drives that choice on one select line, where 1 means antenna A and 0 means antenna B. There is no separate transmit select. Whatever antenna is on the line while the channel is checked is also the antenna used for the transmission that follows.

A 2-bit configuration field chooses the starting antenna. It can pin one antenna, or it can reuse the antenna that produced the most recent good header. When diversity is enabled, the controller switches antennas each time a fixed number of microsecond ticks (16 by default) has passed during acquisition. At every dwell, upstream estimators may present two measurements: an amplitude quality value and a carrier-phase variance value. The controller declares acquisition only when the amplitude value is high enough and the variance value is low enough in the same cycle. At that point the antenna stays fixed. A valid-header strobe that arrives while locked stores this antenna as the new last-good antenna and ends the reception.

Top module: `antdiv_ctrl`

## Requirements
- R1: After reset, `ant_sel` is 0 and `acquired` is 0. The stored last-good antenna is B (0).
- R2: While idle, with mode 2'b11 `ant_sel` becomes 1 (antenna A), and with mode 2'b10 it becomes 0 (antenna B). The output follows a mode change one clock later.
- R3: Mode 2'b01 behaves exactly like mode 2'b10 and drives `ant_sel` to 0.
- R4: With mode 2'b00, the starting antenna is the stored last-good antenna.
- R5: The cycle after `acq_start`, `ant_sel` equals the starting antenna for the current mode, and the block is searching.
- R6: While searching with `cfg_div_en`=1, `ant_sel` inverts in the cycle after every DWELL_TICKS-th `us_tick` counted since `acq_start`.
- R7: While searching with `cfg_div_en`=0, `ant_sel` does not change, whatever number of ticks arrives.
- R8: `acquired` rises the cycle after a cycle in which `meas_valid`=1, `amp_meas` >= {`amp_thr_hi`[6:0],`amp_thr_lo`} (15 bits) and `phs_meas` <= {`phs_thr_hi`,`phs_thr_lo`} (16 bits). If either test fails, or `meas_valid`=0, acquisition is not declared.
- R9: While `acquired`=1, `ant_sel` is frozen and ticks have no effect.
- R10: `hdr_valid` while acquired stores `ant_sel` as the last-good antenna, clears `acquired` and returns the block to idle. `hdr_valid` at any other time is ignored.
- R11: `acq_start` clears `acquired`, restarts the dwell count from zero and begins a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| acq_start | input | 1 | Start (or restart) acquisition |
| hdr_valid | input | 1 | Valid header received |
| meas_valid | input | 1 | Measurements valid this cycle |
| amp_meas | input | 15 | Amplitude quality measurement |
| phs_meas | input | 16 | Carrier phase variance measurement |
| cfg_mode | input | 2 | Start antenna mode: 00 last-good, 01/10 B, 11 A |
| cfg_div_en | input | 1 | Diversity switching enable |
| amp_thr_hi | input | 7 | Amplitude threshold bits 14:8 |
| amp_thr_lo | input | 8 | Amplitude threshold bits 7:0 |
| phs_thr_hi | input | 8 | Phase variance threshold bits 15:8 |
| phs_thr_lo | input | 8 | Phase variance threshold bits 7:0 |
| ant_sel | output | 1 | Antenna select, 1 = A, 0 = B |
| acquired | output | 1 | Acquisition declared |

## Verification
The last-good memory is hard to reach from the ports. It changes only on a header strobe while locked, and it can be observed only when mode 00 is selected for a later start. The stimulus therefore first sends a header strobe during an unlocked search and then restarts in mode 00 to show that nothing was stored. Next it locks on antenna A with measurements that sit exactly on both thresholds, sends the header, and shows that both idle and restarted mode-00 selection now give A. The dwell-restart behaviour is reached by issuing a second start in the middle of a dwell.

// File: rtl/antdiv_pkg.sv
package antdiv_pkg;

    localparam int AMP_W = 15;
    localparam int PHS_W = 16;

    localparam logic ANT_A = 1'b1;
    localparam logic ANT_B = 1'b0;

    typedef enum logic [1:0] {
        SEL_LAST    = 2'b00,
        SEL_ILLEGAL = 2'b01,
        SEL_FIX_B   = 2'b10,
        SEL_FIX_A   = 2'b11
    } ant_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_LOCK   = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic [AMP_W-1:0] amp;
        logic [PHS_W-1:0] phs;
    } qual_t;

    // The illegal code is folded onto antenna B so that the output stays defined.
    function automatic logic start_ant(ant_mode_e m, logic last_good);
        case (m)
            SEL_LAST:  return last_good;
            SEL_FIX_A: return ANT_A;
            default:   return ANT_B;
        endcase
    endfunction

endpackage

// File: rtl/antdiv_qual_cmp.sv
module antdiv_qual_cmp
    import antdiv_pkg::*;
(
    input  qual_t meas,
    input  qual_t thr,
    output logic  pass
);
    logic amp_ok;
    logic phs_ok;

    always_comb begin
        amp_ok = (meas.amp >= thr.amp);
        phs_ok = (meas.phs <= thr.phs);
        pass   = amp_ok && phs_ok;
    end
endmodule

// File: rtl/antdiv_dwell_timer.sv
module antdiv_dwell_timer #(
    parameter int DWELL_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = (DWELL_TICKS > 1) ? $clog2(DWELL_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_comb done = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R11
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clear) && !$past(rst) |-> cnt_q == '0);
endmodule

// File: rtl/antdiv_ctrl.sv
module antdiv_ctrl
    import antdiv_pkg::*;
#(
    parameter int DWELL_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              acq_start,
    input  logic              hdr_valid,
    input  logic              meas_valid,
    input  logic [AMP_W-1:0]  amp_meas,
    input  logic [PHS_W-1:0]  phs_meas,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_div_en,
    input  logic [AMP_W-9:0]  amp_thr_hi,
    input  logic [7:0]        amp_thr_lo,
    input  logic [7:0]        phs_thr_hi,
    input  logic [7:0]        phs_thr_lo,
    output logic              ant_sel,
    output logic              acquired
);
    ctl_state_e st_q;
    logic       ant_q;
    logic       last_q;
    logic       acq_q;
    logic       first_ant;
    logic       qual_pass;
    logic       dwell_done;
    qual_t      meas;
    qual_t      thr;

    always_comb begin
        meas.amp  = amp_meas;
        meas.phs  = phs_meas;
        thr.amp   = {amp_thr_hi, amp_thr_lo};
        thr.phs   = {phs_thr_hi, phs_thr_lo};
        first_ant = start_ant(ant_mode_e'(cfg_mode), last_q);
    end

    antdiv_qual_cmp u_cmp (
        .meas (meas),
        .thr  (thr),
        .pass (qual_pass)
    );

    antdiv_dwell_timer #(.DWELL_TICKS(DWELL_TICKS)) u_dwell (
        .clk   (clk),
        .rst   (rst),
        .clear (acq_start),
        .run   (st_q == ST_SEARCH),
        .tick  (us_tick),
        .done  (dwell_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ant_q  <= ANT_B;
            last_q <= ANT_B;
            acq_q  <= 1'b0;
        end else if (acq_start) begin
            st_q  <= ST_SEARCH;
            ant_q <= first_ant;
            acq_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: ant_q <= first_ant;
                ST_SEARCH: begin
                    if (meas_valid && qual_pass) begin
                        st_q  <= ST_LOCK;
                        acq_q <= 1'b1;
                    end else if (dwell_done && cfg_div_en) begin
                        ant_q <= ~ant_q;
                    end
                end
                ST_LOCK: begin
                    if (hdr_valid) begin
                        last_q <= ant_q;
                        st_q   <= ST_IDLE;
                        acq_q  <= 1'b0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ant_sel  = ant_q;
        acquired = acq_q;
    end

    // R8
    lock_needs_pass_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(acq_q) |-> $past(meas_valid && qual_pass));

    // R9
    lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        acq_q && $past(acq_q) && !$past(rst) |-> $stable(ant_q));

    // R7
    no_div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_SEARCH && $past(st_q == ST_SEARCH) && !$past(cfg_div_en)
        && !$past(acq_start) && !$past(rst) |-> $stable(ant_q));

    // R10
    hdr_store_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(acq_q) && !$past(acq_start) |-> last_q == $past(ant_q));
endmodule

// File: tb/antdiv_ctrl_test.sv
module antdiv_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        us_tick, acq_start, hdr_valid, meas_valid;
    logic [14:0] amp_meas;
    logic [15:0] phs_meas;
    logic [1:0]  cfg_mode;
    logic        cfg_div_en;
    logic [6:0]  amp_thr_hi;
    logic [7:0]  amp_thr_lo, phs_thr_hi, phs_thr_lo;
    logic        ant_sel, acquired;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    antdiv_ctrl uut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .acq_start(acq_start),
        .hdr_valid(hdr_valid), .meas_valid(meas_valid), .amp_meas(amp_meas),
        .phs_meas(phs_meas), .cfg_mode(cfg_mode), .cfg_div_en(cfg_div_en),
        .amp_thr_hi(amp_thr_hi), .amp_thr_lo(amp_thr_lo),
        .phs_thr_hi(phs_thr_hi), .phs_thr_lo(phs_thr_lo),
        .ant_sel(ant_sel), .acquired(acquired)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic start_acq();
        acq_start = 1'b1; step(); acq_start = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1; step(); us_tick = 1'b0; step();
        end
    endtask

    task automatic present(logic [14:0] a, logic [15:0] p);
        amp_meas = a; phs_meas = p; meas_valid = 1'b1; step(); meas_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
        chk("R1 ant_sel", ant_sel, 0);
        chk("R1 acquired", acquired, 0);
    endtask

    task automatic t_fixed_modes();
        cfg_mode = 2'b11; step(); chk("R2 mode11", ant_sel, 1);
        cfg_mode = 2'b10; step(); chk("R2 mode10", ant_sel, 0);
        cfg_mode = 2'b11; step();
        cfg_mode = 2'b01; step(); chk("R3 mode01", ant_sel, 0);
        cfg_mode = 2'b00; step(); chk("R4 mode00 reset last", ant_sel, 0);
    endtask

    task automatic t_diversity();
        cfg_mode = 2'b11; cfg_div_en = 1'b1;
        start_acq();
        chk("R5 start A", ant_sel, 1);
        ticks(15); chk("R6 before dwell end", ant_sel, 1);
        ticks(1);  chk("R6 first toggle", ant_sel, 0);
        ticks(15); chk("R6 mid second dwell", ant_sel, 0);
        ticks(1);  chk("R6 second toggle", ant_sel, 1);
    endtask

    task automatic t_no_diversity();
        cfg_mode = 2'b10; cfg_div_en = 1'b0;
        start_acq();
        chk("R5 start B", ant_sel, 0);
        ticks(40); chk("R7 held", ant_sel, 0);
    endtask

    task automatic t_restart();
        cfg_mode = 2'b11; cfg_div_en = 1'b1;
        start_acq(); ticks(10);
        start_acq();
        ticks(15); chk("R11 dwell restarted", ant_sel, 1);
        ticks(1);  chk("R11 toggle after restart", ant_sel, 0);
    endtask

    task automatic t_hdr_ignored();
        cfg_mode = 2'b11; cfg_div_en = 1'b0;
        start_acq();
        hdr_valid = 1'b1; step(); hdr_valid = 1'b0;
        chk("R10 no lock no change", acquired, 0);
        cfg_mode = 2'b00; start_acq();
        chk("R10 unlocked hdr ignored", ant_sel, 0);
    endtask

    task automatic t_threshold();
        amp_thr_hi = 7'h12; amp_thr_lo = 8'h34;
        phs_thr_hi = 8'h04; phs_thr_lo = 8'h56;
        cfg_mode = 2'b11; cfg_div_en = 1'b1;
        start_acq();
        amp_meas = 15'h1234; phs_meas = 16'h0456; meas_valid = 1'b0; step();
        chk("R8 invalid ignored", acquired, 0);
        present(15'h1233, 16'h0400); chk("R8 amp low", acquired, 0);
        present(15'h1234, 16'h0457); chk("R8 phase high", acquired, 0);
        present(15'h7fff, 16'hffff); chk("R8 only amp pass", acquired, 0);
        present(15'h1234, 16'h0456); chk("R8 both at bound", acquired, 1);
        chk("R8 antenna A", ant_sel, 1);
        ticks(40);
        chk("R9 frozen ant", ant_sel, 1);
        chk("R9 still acquired", acquired, 1);
        cfg_mode = 2'b10;
        hdr_valid = 1'b1; step(); hdr_valid = 1'b0;
        chk("R10 cleared", acquired, 0);
        cfg_mode = 2'b00; step();
        chk("R10 R4 last stored A", ant_sel, 1);
        start_acq();
        chk("R4 start on last A", ant_sel, 1);
        present(15'h2000, 16'h0001); chk("R8 lock again", acquired, 1);
        start_acq();
        chk("R11 start clears", acquired, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; us_tick = 0; acq_start = 0; hdr_valid = 0; meas_valid = 0;
        amp_meas = 0; phs_meas = 0; cfg_mode = 2'b10; cfg_div_en = 0;
        amp_thr_hi = 7'h7f; amp_thr_lo = 8'hff; phs_thr_hi = 0; phs_thr_lo = 0;
        t_reset();
        t_fixed_modes();
        t_diversity();
        t_no_diversity();
        t_restart();
        t_hdr_ignored();
        t_threshold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule